// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This block forms the memory address for one load or store and, where the indexing mode calls for it, the new value of the base register. The caller presents the base register value, an immediate constant, an index register value, a shift amount, an add/subtract select, an offset source select and a 2-bit mode code, together with `in_valid`. One cycle later the block presents the address, the writeback value and a writeback-enable strobe, qualified by `out_valid`.

There are three indexing modes. In plain offset mode the bus address is the adjusted base and the base register is left alone. In pre-indexed mode the adjusted base both drives the bus and is written back. In post-indexed mode the bus sees the untouched base, and the adjusted base is written back. The offset is either the immediate, the index register, or the index register shifted left. All arithmetic wraps modulo 2^32.

Top module: `agu_ls`

## Requirements
- R1: With `mode` = 2'b00 (offset), `addr` equals `base` adjusted by the offset and `wb_en` is 0.
- R2: With `mode` = 2'b01 (pre-indexed), `addr` and `wb_data` both equal `base` adjusted by the offset, and `wb_en` is 1.
- R3: With `mode` = 2'b10 (post-indexed), `addr` equals the unmodified `base`, `wb_data` equals `base` adjusted by the offset, and `wb_en` is 1.
- R4: `sub` = 0 adds the offset to `base`; `sub` = 1 subtracts it.
- R5: `src` = 2'b00 selects `imm` as offset, 2'b01 selects `idx`, and 2'b10 or 2'b11 selects `idx` logically shifted left by `shamt` (0 to 31), bits shifted past bit 31 being discarded.
- R6: With `mode` = 2'b11 (reserved), `err` is 1, `wb_en` is 0, and `addr` and `wb_data` are 0.
- R7: Address arithmetic wraps modulo 2^32 with no fault indication.
- R8: Every cycle with `in_valid` = 1 yields `out_valid` = 1 in the following cycle only; when `out_valid` is 0, `wb_en` and `err` are 0.
- R9: Synchronous active-high `rst` clears `out_valid`, `wb_en` and `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 2 | Indexing mode code |
| src | input | 2 | Offset source select |
| sub | input | 1 | 1 subtracts the offset, 0 adds it |
| base | input | 32 | Base register value |
| imm | input | 32 | Immediate offset |
| idx | input | 32 | Index register value |
| shamt | input | 5 | Left shift applied to the index register |
| out_valid | output | 1 | Result valid, one cycle per request |
| addr | output | 32 | Effective address |
| wb_data | output | 32 | Value to write back to the base register |
| wb_en | output | 1 | Base writeback strobe |
| err | output | 1 | Reserved mode code seen |

## Verification
The two functions that meet in one cycle are address generation and base writeback: in pre- and post-indexed modes both outputs are produced by the same request and must disagree or agree in exactly the right way. The bench drives requests back to back across every mode, source, direction and a set of operands chosen to wrap past zero and past the top of the address space, and judges `addr`, `wb_data` and `wb_en` together against values computed arithmetically. Idle gaps and a reset check confirm that strobes never appear without a request.

// File: rtl/agu_ls.sv
module agu_ls #(
  parameter int AW  = 32,
  parameter int SHW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [1:0]     mode,
  input  logic [1:0]     src,
  input  logic           sub,
  input  logic [AW-1:0]  base,
  input  logic [AW-1:0]  imm,
  input  logic [AW-1:0]  idx,
  input  logic [SHW-1:0] shamt,
  output logic           out_valid,
  output logic [AW-1:0]  addr,
  output logic [AW-1:0]  wb_data,
  output logic           wb_en,
  output logic           err
);
  localparam logic [1:0] M_OFS  = 2'b00;
  localparam logic [1:0] M_PRE  = 2'b01;
  localparam logic [1:0] M_POST = 2'b10;
  localparam logic [1:0] M_RSV  = 2'b11;

  logic [AW-1:0] ofs, sum;
  logic          bad;

  assign ofs = (src == 2'b00) ? imm :
               (src == 2'b01) ? idx : (idx << shamt);
  assign sum = sub ? (base - ofs) : (base + ofs);
  assign bad = (mode == M_RSV);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      err       <= 1'b0;
      addr      <= '0;
      wb_data   <= '0;
    end else begin
      out_valid <= in_valid;
      wb_en     <= in_valid && (mode == M_PRE || mode == M_POST);
      err       <= in_valid && bad;
      if (in_valid) begin
        addr    <= bad ? '0 : (mode == M_POST) ? base : sum;
        wb_data <= (bad || mode == M_OFS) ? '0 : sum;
      end
    end
  end
endmodule

module agu_ls_chk #(
  parameter int AW  = 32,
  parameter int SHW = 5
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [1:0]     mode,
  input logic [AW-1:0]  base,
  input logic           out_valid,
  input logic [AW-1:0]  addr,
  input logic [AW-1:0]  wb_data,
  input logic           wb_en,
  input logic           err
);
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid) && !$past(rst) |-> out_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> !wb_en && !err);
  a_r1_no_writeback: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(mode) == 2'b00 |-> !wb_en && !err);
  a_r2_pre_same: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(mode) == 2'b01 |-> wb_en && wb_data == addr);
  a_r3_post_base: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(mode) == 2'b10 |-> wb_en && addr == $past(base));
  a_r6_reserved: assert property (@(posedge clk) disable iff (rst)
    out_valid && $past(mode) == 2'b11 |-> err && !wb_en);
endmodule

bind agu_ls agu_ls_chk #(.AW(AW), .SHW(SHW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .base(base),
  .out_valid(out_valid), .addr(addr), .wb_data(wb_data), .wb_en(wb_en),
  .err(err)
);

// File: tb/agu_ls_test.sv
module agu_ls_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        in_valid = 0;
  logic [1:0]  mode = 0, src = 0;
  logic        sub = 0;
  logic [31:0] base = 0, imm = 0, idx = 0;
  logic [4:0]  shamt = 0;
  logic        out_valid, wb_en, err;
  logic [31:0] addr, wb_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  agu_ls uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode), .src(src),
    .sub(sub), .base(base), .imm(imm), .idx(idx), .shamt(shamt),
    .out_valid(out_valid), .addr(addr), .wb_data(wb_data), .wb_en(wb_en),
    .err(err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [1:0] m, input logic [1:0] s, input bit sb,
                         input logic [31:0] b, input logic [31:0] im,
                         input logic [31:0] ix, input logic [4:0] sh);
    logic [63:0] wide;
    logic [31:0] o, adj, ea, wb;
    bit we, er;
    string tag;
    @(negedge clk);
    in_valid = 1; mode = m; src = s; sub = sb; base = b; imm = im; idx = ix; shamt = sh;
    // R5: offset source; shifted bits above 31 discarded
    wide = {32'd0, ix} << sh;
    o = (s == 2'b00) ? im : (s == 2'b01) ? ix : wide[31:0];
    // R4, R7: add or subtract modulo 2^32
    wide = sb ? ({32'd0, b} + 64'h1_0000_0000 - {32'd0, o}) : ({32'd0, b} + {32'd0, o});
    adj = wide[31:0];
    case (m)
      2'b00: begin ea = adj; wb = 0;   we = 0; er = 0; tag = "R1 R4 R5 R7"; end
      2'b01: begin ea = adj; wb = adj; we = 1; er = 0; tag = "R2 R4 R5 R7"; end
      2'b10: begin ea = b;   wb = adj; we = 1; er = 0; tag = "R3 R4 R5 R7"; end
      default: begin ea = 0; wb = 0;   we = 0; er = 1; tag = "R6"; end
    endcase
    @(posedge clk); #1;
    check(out_valid === 1'b1, {tag, " R8 out_valid"}, {31'd0, out_valid}, 32'd1);
    check(addr === ea, {tag, " addr"}, addr, ea);
    if (m != 2'b00 && m != 2'b11)
      check(wb_data === wb, {tag, " wb_data"}, wb_data, wb);
    check(wb_en === we && err === er, {tag, " wb_en/err"},
          {30'd0, wb_en, err}, {30'd0, we, er});
  endtask

  initial begin
    logic [31:0] bases [4] = '{32'h0, 32'hFFFF_FFF0, 32'h8000_0000, 32'h1234_5678};
    logic [31:0] imms  [2] = '{32'h4, 32'h0000_0FFF};
    logic [31:0] idxs  [2] = '{32'h1, 32'h8000_0001};
    logic [4:0]  shs   [4] = '{5'd0, 5'd1, 5'd5, 5'd31};
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid && !wb_en && !err, "R9 reset", {29'd0, out_valid, wb_en, err}, 32'd0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    check(!out_valid && !wb_en && !err, "R8 idle", {29'd0, out_valid, wb_en, err}, 32'd0);

    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int sb = 0; sb < 2; sb++)
          for (int bi = 0; bi < 4; bi++)
            for (int xi = 0; xi < 2; xi++)
              for (int hi = 0; hi < 4; hi++)
                run_one(m[1:0], s[1:0], sb[0], bases[bi], imms[xi], idxs[xi], shs[hi]);

    // R7 explicit wrap: 0xFFFFFFF0 + 0x20 = 0x10, 0x4 - 0x8 = 0xFFFFFFFC
    run_one(2'b01, 2'b00, 1'b0, 32'hFFFF_FFF0, 32'h20, 32'h0, 5'd0);
    run_one(2'b10, 2'b01, 1'b1, 32'h4, 32'h0, 32'h8, 5'd0);

    @(negedge clk); in_valid = 0; mode = 2'b11;
    @(posedge clk); #1;
    check(!out_valid && !wb_en && !err, "R8 single pulse", {29'd0, out_valid, wb_en, err}, 32'd0);
    @(posedge clk); #1;
    check(!out_valid && !wb_en && !err, "R8 no request no err", {29'd0, out_valid, wb_en, err}, 32'd0);

    run_one(2'b01, 2'b10, 1'b0, 32'h100, 32'h0, 32'h3, 5'd4);
    @(negedge clk); rst = 1;
    @(posedge clk); #1;
    check(!out_valid && !wb_en && !err, "R9 reset during request", {29'd0, out_valid, wb_en, err}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule